// File: doc/BRIEF.md
# Vector Condition-to-Integer Result Packer

This block walks a vector of 4-bit condition fields one element per clock. For every element it gates the four field bits with a per-bit enable, compares each enabled bit with a per-bit polarity, and reduces the four outcomes to one bit, either with AND or with OR. The resulting bits are packed into 64-bit integer destination registers. The packing density (1, 2, 4 or 8 results per register) comes from a 2-bit selector that belongs to the source side. A scalar destination instead collects every result, one bit per element, in a single register.

A start pulse captures the job: the vector length (0 to 64), the first field index with a vector/scalar flag, the enable and polarity nibbles, the reduce selector, the packing selector, the destination vector/scalar flag and the first destination register. The block drives a field index to a combinational read port. It issues one write per destination word, either when the word is full or after the last element, and then pulses done.

Top module: `cond_pack_seq`

## Requirements
- R1: With the source flag set, element i reads field (base+i) modulo the field count. With it clear, every element reads field base.
- R2: Each result is computed from t[k] = en[k] AND (pol[k] == field[k]) for k = 0..3, where field bit k is bit k of the read data. The result is the OR of t when or_sel=1 and the AND of t when or_sel=0.
- R3: With the destination flag set, pack_sel values 00, 01, 10 and 11 give P = 1, 2, 4 and 8 results per word. Result i goes to register (dst_base + i/P) modulo the register count, at bit i mod P counted from the LSB.
- R4: In every word written with the destination flag set, all bits at position P and above are zero.
- R5: With the destination flag clear, result i goes to bit i of register dst_base. Exactly one write is issued when the vector length is nonzero.
- R6: When the last word is only partly filled, its unused result positions hold zero.
- R7: One element is handled per clock. done is a one-cycle pulse that is visible VL cycles after the start edge, and the final word is written in that same cycle.
- R8: With a vector length of 0, no write is issued and done pulses in the cycle after the start edge.
- R9: A start pulse that arrives while busy is high is ignored. The running job finishes with its own configuration and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (ignored while busy) |
| vl | input | 7 | Number of elements, 0..64 |
| src_base | input | 6 | First condition field index |
| src_vec | input | 1 | 1: field index steps per element |
| en_mask | input | 4 | Per-bit enable |
| pol_mask | input | 4 | Per-bit compare polarity |
| or_sel | input | 1 | 1: OR reduce, 0: AND reduce |
| pack_sel | input | 2 | Results per word: 1, 2, 4, 8 |
| dst_vec | input | 1 | 1: packed vector destination, 0: single register |
| dst_base | input | 7 | First destination register |
| fld_idx | output | 6 | Condition field read index |
| fld_data | input | 4 | Field read data, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 7 | Register write index |
| wr_data | output | 64 | Register write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the boundary between words at each packing density. A slot counter that wraps one position late would merge two words, and one that wraps early would drop a result. It runs vector lengths that leave a partial final word, where a missing flush would lose the tail and a stale accumulator would leak bits from the previous job. Source and destination base values near the top of their ranges check wraparound of the index. Vector length zero is checked for a spurious write. A second start during a run is checked for corrupting the captured configuration.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    PACK1 = 2'b00,
    PACK2 = 2'b01,
    PACK4 = 2'b10,
    PACK8 = 2'b11
  } pack_e;

  // index of the last result slot in a word
  function automatic logic [5:0] last_slot(input logic dvec, input pack_e ps);
    logic [5:0] r;
    if (!dvec) r = 6'(WORD_W - 1);
    else begin
      case (ps)
        PACK1:   r = 6'd0;
        PACK2:   r = 6'd1;
        PACK4:   r = 6'd3;
        default: r = 6'd7;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/cond_reduce.sv
module cond_reduce #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] fld,
  input  logic [FW-1:0] en,
  input  logic [FW-1:0] pol,
  input  logic          or_sel,
  output logic          res
);
  logic [FW-1:0] hit;
  for (genvar k = 0; k < FW; k++) begin : g_bit
    assign hit[k] = en[k] & ~(pol[k] ^ fld[k]);
  end
  assign res = or_sel ? (|hit) : (&hit);
endmodule

// File: rtl/elem_seq.sv
module elem_seq #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VL_W-1:0] vl,
  output logic            accept,
  output logic            busy,
  output logic            last,
  output logic [VL_W-1:0] elem,
  output logic            done
);
  logic [VL_W-1:0] vl_q;

  assign accept = start & ~busy;
  assign last   = busy & (elem == vl_q - VL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      elem <= '0;
      vl_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        elem <= '0;
        vl_q <= vl;
        if (vl == '0) done <= 1'b1;
        else          busy <= 1'b1;
      end else if (busy) begin
        elem <= elem + VL_W'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/word_pack.sv
module word_pack
  import cpk_pkg::*;
#(
  parameter int RIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic              res,
  input  logic              last,
  input  logic              dvec,
  input  pack_e             psel,
  input  logic [RIDX_W-1:0] rbase,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  localparam int POS_W = $clog2(WORD_W);

  logic [WORD_W-1:0] acc, acc_n;
  logic [POS_W-1:0]  slot, lim;
  logic [RIDX_W-1:0] wcnt;
  logic              flush;

  assign lim   = POS_W'(last_slot(dvec, psel));
  assign acc_n = acc | (WORD_W'(res) << slot);
  assign flush = (slot == lim) | last;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      slot    <= '0;
      wcnt    <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clear) begin
        acc  <= '0;
        slot <= '0;
        wcnt <= '0;
      end else if (step) begin
        if (flush) begin
          wr_en   <= 1'b1;
          wr_data <= acc_n;
          wr_idx  <= rbase + wcnt;
          wcnt    <= wcnt + RIDX_W'(1);
          acc     <= '0;
          slot    <= '0;
        end else begin
          acc  <= acc_n;
          slot <= slot + POS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cond_pack_seq.sv
module cond_pack_seq
  import cpk_pkg::*;
#(
  parameter int FIELD_CNT = 64,
  parameter int REG_CNT   = 128,
  parameter int VL_MAX    = 64,
  parameter int FW        = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(VL_MAX+1)-1:0]  vl,
  input  logic [$clog2(FIELD_CNT)-1:0] src_base,
  input  logic                         src_vec,
  input  logic [FW-1:0]                en_mask,
  input  logic [FW-1:0]                pol_mask,
  input  logic                         or_sel,
  input  logic [1:0]                   pack_sel,
  input  logic                         dst_vec,
  input  logic [$clog2(REG_CNT)-1:0]   dst_base,
  output logic [$clog2(FIELD_CNT)-1:0] fld_idx,
  input  logic [FW-1:0]                fld_data,
  output logic                         wr_en,
  output logic [$clog2(REG_CNT)-1:0]   wr_idx,
  output logic [WORD_W-1:0]            wr_data,
  output logic                         busy,
  output logic                         done
);
  localparam int VL_W   = $clog2(VL_MAX + 1);
  localparam int FIDX_W = $clog2(FIELD_CNT);
  localparam int RIDX_W = $clog2(REG_CNT);

  logic              accept, last, res;
  logic [VL_W-1:0]   elem;
  logic [FIDX_W-1:0] base_q;
  logic              svec_q, dvec_q, or_q;
  logic [FW-1:0]     en_q, pol_q;
  pack_e             psel_q;
  logic [RIDX_W-1:0] rbase_q;

  elem_seq #(.VL_W(VL_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .accept(accept),
    .busy(busy), .last(last), .elem(elem), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      or_q    <= 1'b0;
      en_q    <= '0;
      pol_q   <= '0;
      psel_q  <= PACK1;
      rbase_q <= '0;
    end else if (accept) begin
      base_q  <= src_base;
      svec_q  <= src_vec;
      dvec_q  <= dst_vec;
      or_q    <= or_sel;
      en_q    <= en_mask;
      pol_q   <= pol_mask;
      psel_q  <= pack_e'(pack_sel);
      rbase_q <= dst_base;
    end
  end

  assign fld_idx = svec_q ? base_q + FIDX_W'(elem) : base_q;

  cond_reduce #(.FW(FW)) red_i (
    .fld(fld_data), .en(en_q), .pol(pol_q), .or_sel(or_q), .res(res)
  );

  word_pack #(.RIDX_W(RIDX_W)) pack_i (
    .clk(clk), .rst(rst), .clear(accept), .step(busy), .res(res),
    .last(last), .dvec(dvec_q), .psel(psel_q), .rbase(rbase_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );
endmodule

// File: rtl/cpk_chk.sv
module cpk_chk #(
  parameter int FIDX_W = 6,
  parameter int VL_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [VL_W-1:0]   vl,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [63:0]       wr_data,
  input logic [FIDX_W-1:0] fld_idx,
  input logic              svec_q,
  input logic              dvec_q,
  input logic [1:0]        psel_q
);
  logic [63:0] high_bits;
  assign high_bits = ~((64'd1 << (7'd1 << psel_q)) - 64'd1);

  // R8
  vl_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl == '0) |=> (done && !wr_en));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  write_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dvec_q) |-> ((wr_data & high_bits) == 64'd0));

  // R1
  vec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && svec_q) |-> (fld_idx == $past(fld_idx) + FIDX_W'(1)));

  // R1
  scalar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !svec_q) |-> $stable(fld_idx));
endmodule

bind cond_pack_seq cpk_chk #(.FIDX_W(FIDX_W), .VL_W(VL_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .vl(vl), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_data(wr_data), .fld_idx(fld_idx), .svec_q(svec_q),
  .dvec_q(dvec_q), .psel_q(psel_q)
);

// File: tb/cond_pack_seq_tb.sv
module cond_pack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [5:0]  src_base = '0;
  logic        src_vec = 1'b0;
  logic [3:0]  en_mask = '0, pol_mask = '0;
  logic        or_sel = 1'b0;
  logic [1:0]  pack_sel = '0;
  logic        dst_vec = 1'b0;
  logic [6:0]  dst_base = '0;
  logic [5:0]  fld_idx;
  logic [3:0]  fld_data;
  logic        wr_en, busy, done;
  logic [6:0]  wr_idx;
  logic [63:0] wr_data;

  typedef struct packed { logic [6:0] idx; logic [63:0] data; } wr_t;
  wr_t exp_q[$];
  logic [3:0] fmem [64];
  int checks = 0, errors = 0;
  string tag = "R3";

  always #10 clk = ~clk;

  cond_pack_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .src_base(src_base),
    .src_vec(src_vec), .en_mask(en_mask), .pol_mask(pol_mask), .or_sel(or_sel),
    .pack_sel(pack_sel), .dst_vec(dst_vec), .dst_base(dst_base),
    .fld_idx(fld_idx), .fld_data(fld_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  assign fld_data = fmem[fld_idx];

  function automatic logic ref_bit(logic [3:0] f, logic [3:0] e, logic [3:0] p, logic o);
    logic [3:0] t;
    t = e & ~(p ^ f);
    return o ? (|t) : (&t);
  endfunction

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected write idx=%0d data=%h, expected none", tag, wr_idx, wr_data);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (e.idx !== wr_idx || e.data !== wr_data) begin
          errors++;
          $display("FAIL %s: write idx=%0d data=%h, expected idx=%0d data=%h",
                   tag, wr_idx, wr_data, e.idx, e.data);
        end
      end
    end
  end

  task automatic run(string t, int n, int b, bit sv, logic [3:0] e, logic [3:0] p,
                     bit o, int ps, bit dv, int rb, bit intrude);
    logic [63:0] words [64];
    int per, nw, k;
    tag = t;
    for (int w = 0; w < 64; w++) words[w] = '0;
    per = dv ? (1 << ps) : 64;
    for (int i = 0; i < n; i++) begin
      int fi;
      fi = sv ? (b + i) % 64 : b;
      words[i / per][i % per] = ref_bit(fmem[fi], e, p, o);
    end
    nw = (n + per - 1) / per;
    for (int w = 0; w < nw; w++) exp_q.push_back({7'((rb + w) % 128), words[w]});
    @(negedge clk);
    vl = 7'(n); src_base = 6'(b); src_vec = sv; en_mask = e; pol_mask = p;
    or_sel = o; pack_sel = 2'(ps); dst_vec = dv; dst_base = 7'(rb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
      if (intrude && k == 2) begin
        vl = 7'd3; src_base = 6'd40; pack_sel = 2'd0; dst_base = 7'd99;
        en_mask = 4'hF; pol_mask = 4'h0; or_sel = 1'b1; start = 1'b1;
      end else start = 1'b0;
    end
    #1;
    checks++;
    if (k != n) begin
      errors++;
      $display("FAIL %s/R7: done after %0d cycles, expected %0d", t, k, n);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d writes missing, expected 0", t, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 64; j++) fmem[j] = 4'((j * 7 + 3) ^ (j >> 2));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (wr_en !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL reset: wr_en=%b busy=%b done=%b, expected 0 0 0", wr_en, busy, done);
    end
    run("R3", 5, 0, 1, 4'hF, 4'h0, 1, 0, 1, 10, 0);
    run("R2", 12, 5, 1, 4'b0101, 4'b0100, 0, 3, 1, 20, 0);
    run("R6", 7, 17, 1, 4'hF, 4'hA, 1, 1, 1, 30, 0);
    run("R4", 9, 33, 1, 4'b1100, 4'b1000, 1, 2, 1, 40, 0);
    run("R1", 64, 10, 1, 4'b0011, 4'b0001, 0, 3, 1, 124, 0);
    run("R3", 11, 60, 1, 4'b1001, 4'b0000, 1, 1, 1, 126, 0);
    run("R5", 64, 2, 1, 4'hF, 4'h5, 1, 0, 0, 50, 0);
    run("R5", 13, 30, 1, 4'b0110, 4'b0010, 0, 2, 0, 51, 0);
    run("R1", 6, 3, 0, 4'hF, 4'h3, 1, 3, 1, 60, 0);
    run("R8", 0, 0, 1, 4'hF, 4'h0, 1, 0, 1, 70, 0);
    run("R9", 8, 12, 1, 4'b0111, 4'b0101, 1, 2, 1, 80, 1);
    run("R2", 16, 44, 1, 4'hF, 4'h9, 0, 2, 1, 90, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule